// File: doc/BRIEF.md
# PCI Memory Read Burst Master

This block is the bus-facing engine that performs a 32-bit PCI memory read burst for a local requester. A local client raises a request together with a start address, a burst length and byte enables. The block then requests the bus and waits for a grant while the bus is idle. It runs the address phase, turns the AD lines around and steps through the data phases. Each word it reads is handed back to the client on a read-data output, marked by a transfer strobe.

Local flow control arrives on a single ready input. The block registers that input and uses it to decide, one cycle later, whether IRDY# is asserted or whether a master wait state is inserted. A remaining-word counter decides when FRAME# drops for the final phase. A 4-bit status code tells the client where the transaction stands. Only normal completion is handled. Target retry, disconnect, abort, parity and latency timers are outside this block.

Top module: `pci_rd_master`

## Requirements
- R1: The status output reads 0 when idle and moves to 1 (address loading) in the cycle after the local request is seen high. It reads 2 (bus transaction) from the address phase until the final completion, and then 3 (bus termination) for exactly one cycle before returning to 0.
- R2: The address phase shows FRAME# low, AD driven with the latched start address, C/BE# driven with the memory read command 4'b0110, status 2, and the remaining-word count loaded with the requested length. A requested length of 0 is treated as 1.
- R3: The address phase begins only in the cycle after a loading cycle in which GNT# was low and the bus FRAME# and IRDY# inputs had both been high in the cycle before.
- R4: In the cycle after the address phase, AD is released. From that cycle until the final completion, C/BE# carries the latched byte enables.
- R5: In a data-phase cycle, IRDY# is low only if the local ready input was high in the previous cycle. The exception is that IRDY#, once low, stays low until its data phase completes.
- R6: A data phase completes in a cycle where IRDY#, TRDY# and DEVSEL# are all low. In the next cycle the read-data output holds the AD word of that phase and the remaining-word count is one lower.
- R7: The transfer strobe is high in the cycle after a completion exactly when local ready was high in the completion cycle. In every other cycle it is low.
- R8: FRAME# is driven high in the cycle where IRDY# is low for the final data phase. It stays high until it is released.
- R9: In the cycle after the final completion, FRAME#, AD and C/BE# are released, IRDY# is driven high, status reads 3 and the termination code reads 1 (normal). Outside that cycle the code reads 0. IRDY# is released one cycle later.
- R10: REQ# is low throughout address loading. In the cycle after FRAME# is first asserted, REQ# is high if the local request was low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local request for a read burst |
| loc_addr | input | 32 | Burst start address |
| loc_len | input | LEN_W | Burst length in words (0 is treated as 1) |
| loc_be | input | 4 | Active-low byte enables for the data phases |
| loc_ready | input | 1 | Local side can accept data |
| rd_data | output | 32 | Last completed read word |
| rd_xfer | output | 1 | Strobe marking rd_data as handed over |
| burst_left | output | LEN_W | Words not yet completed |
| status | output | 4 | 0 idle, 1 loading, 2 transaction, 3 termination |
| term_code | output | 2 | 1 during normal termination, else 0 |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| bus_frame_n | input | 1 | Observed FRAME# on the bus |
| bus_irdy_n | input | 1 | Observed IRDY# on the bus |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| ad_i | input | 32 | AD lines as seen on the bus |
| ad_o | output | 32 | AD value driven |
| ad_oe | output | 1 | AD output enable |
| cbe_o | output | 4 | Command / byte enable value driven |
| cbe_oe | output | 1 | C/BE# output enable |
| frame_n | output | 1 | FRAME# value driven |
| frame_oe | output | 1 | FRAME# output enable |
| irdy_n | output | 1 | IRDY# value driven |
| irdy_oe | output | 1 | IRDY# output enable |

## Verification
Several rules are checked on every cycle by properties: the address phase contents, the bus-idle gate on its start, the turnaround, IRDY# staying low until its phase completes, FRAME# high only while IRDY# is low, the strobe tracing back to a completion with local ready, and the one-cycle termination with the later IRDY# release. The bench sweeps burst lengths 0 to 4 against several local-ready and target-ready patterns. Only those runs show that each word reaches the client with the right value and in the right order, that the count falls in step, that FRAME# drops on the right phase, and that REQ# follows the request.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

    localparam int BUS_W = 32;
    localparam int BE_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_LOAD = 4'd1,
        ST_XACT = 4'd2,
        ST_TERM = 4'd3
    } rd_status_e;

    localparam logic [BE_W-1:0] CMD_MEM_READ = 4'b0110;
    localparam logic [1:0]      TERM_NONE    = 2'd0;
    localparam logic [1:0]      TERM_NORMAL  = 2'd1;

    typedef struct packed {
        rd_status_e             status;
        logic                   addr_ph;
        logic                   frame_n;
        logic                   frame_oe;
        logic                   ad_oe;
        logic                   cbe_oe;
        logic [BE_W-1:0]        cbe;
        logic                   irdy_n;
        logic                   irdy_oe;
        logic [BUS_W-1:0]       addr;
        logic [BE_W-1:0]        be;
    } seq_state_t;

endpackage

// File: rtl/pci_rd_reqctl.sv
module pci_rd_reqctl (
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req,
    input  logic in_load,
    input  logic gnt_n,
    input  logic bus_frame_n,
    input  logic bus_irdy_n,
    output logic req_n,
    output logic go
);
    logic idle_d, idle_q;
    logic req_n_d, req_n_q;

    always_comb begin
        idle_d  = bus_frame_n && bus_irdy_n;
        go      = in_load && !gnt_n && idle_q;
        req_n_d = (in_load && !go) ? 1'b0 : !loc_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q  <= 1'b0;
            req_n_q <= 1'b1;
        end else begin
            idle_q  <= idle_d;
            req_n_q <= req_n_d;
        end
    end

    assign req_n = req_n_q;
endmodule

// File: rtl/pci_rd_burstctr.sv
module pci_rd_burstctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             dec,
    output logic [LEN_W-1:0] count,
    output logic [LEN_W-1:0] rem_after
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len   = (load_len == '0) ? ONE : load_len;
        rem_after = dec ? (cnt_q - ONE) : cnt_q;
        if (load)
            cnt_d = eff_len;
        else
            cnt_d = rem_after;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pci_rd_rxcap.sv
module pci_rd_rxcap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              loc_ready,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_xfer
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              xfer_d, xfer_q;

    always_comb begin
        data_d = complete ? ad_i : data_q;
        xfer_d = complete && loc_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            xfer_q <= 1'b0;
        end else begin
            data_q <= data_d;
            xfer_q <= xfer_d;
        end
    end

    assign rd_data = data_q;
    assign rd_xfer = xfer_q;
endmodule

// File: rtl/pci_rd_master.sv
module pci_rd_master
    import pci_rd_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  logic [31:0]      loc_addr,
    input  logic [LEN_W-1:0] loc_len,
    input  logic [3:0]       loc_be,
    input  logic             loc_ready,
    output logic [31:0]      rd_data,
    output logic             rd_xfer,
    output logic [LEN_W-1:0] burst_left,
    output logic [3:0]       status,
    output logic [1:0]       term_code,
    output logic             req_n,
    input  logic             gnt_n,
    input  logic             bus_frame_n,
    input  logic             bus_irdy_n,
    input  logic             trdy_n,
    input  logic             devsel_n,
    input  logic [31:0]      ad_i,
    output logic [31:0]      ad_o,
    output logic             ad_oe,
    output logic [3:0]       cbe_o,
    output logic             cbe_oe,
    output logic             frame_n,
    output logic             frame_oe,
    output logic             irdy_n,
    output logic             irdy_oe
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_state_t       st_d, st_q;
    logic             go;
    logic             load;
    logic             complete;
    logic [LEN_W-1:0] rem_after;
    logic [LEN_W-1:0] count;
    logic             in_load;

    assign in_load = (st_q.status == ST_LOAD);

    // data phase completes when both sides are ready and the target claimed
    assign complete = (st_q.status == ST_XACT) && !st_q.addr_ph &&
                      !st_q.irdy_n && !trdy_n && !devsel_n;

    pci_rd_reqctl u_reqctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_req     (loc_req),
        .in_load     (in_load),
        .gnt_n       (gnt_n),
        .bus_frame_n (bus_frame_n),
        .bus_irdy_n  (bus_irdy_n),
        .req_n       (req_n),
        .go          (go)
    );

    pci_rd_burstctr #(.LEN_W(LEN_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_len  (loc_len),
        .dec       (complete),
        .count     (count),
        .rem_after (rem_after)
    );

    pci_rd_rxcap #(.DATA_W(BUS_W)) u_rxcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .loc_ready (loc_ready),
        .ad_i      (ad_i),
        .rd_data   (rd_data),
        .rd_xfer   (rd_xfer)
    );

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q.status)
            ST_IDLE: begin
                if (loc_req) st_d.status = ST_LOAD;
            end
            ST_LOAD: begin
                if (go) begin
                    load          = 1'b1;
                    st_d.status   = ST_XACT;
                    st_d.addr_ph  = 1'b1;
                    st_d.frame_n  = 1'b0;
                    st_d.frame_oe = 1'b1;
                    st_d.ad_oe    = 1'b1;
                    st_d.cbe      = CMD_MEM_READ;
                    st_d.cbe_oe   = 1'b1;
                    st_d.irdy_n   = 1'b1;
                    st_d.irdy_oe  = 1'b1;
                    st_d.addr     = loc_addr;
                    st_d.be       = loc_be;
                end
            end
            ST_XACT: begin
                st_d.addr_ph = 1'b0;
                st_d.ad_oe   = 1'b0;
                st_d.cbe     = st_q.be;
                if (complete && rem_after == '0) begin
                    st_d.status   = ST_TERM;
                    st_d.frame_n  = 1'b1;
                    st_d.frame_oe = 1'b0;
                    st_d.cbe_oe   = 1'b0;
                    st_d.irdy_n   = 1'b1;
                end else begin
                    // IRDY# holds once asserted; otherwise follows last cycle's ready
                    if (!st_q.irdy_n && !complete)
                        st_d.irdy_n = 1'b0;
                    else
                        st_d.irdy_n = !loc_ready;
                    st_d.frame_n = st_q.frame_n ||
                                   ((rem_after == ONE) && !st_d.irdy_n);
                end
            end
            ST_TERM: begin
                st_d.status  = ST_IDLE;
                st_d.irdy_oe = 1'b0;
                st_d.irdy_n  = 1'b1;
            end
            default: begin
                st_d.status = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status   <= ST_IDLE;
            st_q.addr_ph  <= 1'b0;
            st_q.frame_n  <= 1'b1;
            st_q.frame_oe <= 1'b0;
            st_q.ad_oe    <= 1'b0;
            st_q.cbe_oe   <= 1'b0;
            st_q.cbe      <= '0;
            st_q.irdy_n   <= 1'b1;
            st_q.irdy_oe  <= 1'b0;
            st_q.addr     <= '0;
            st_q.be       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status     = st_q.status;
    assign term_code  = (st_q.status == ST_TERM) ? TERM_NORMAL : TERM_NONE;
    assign burst_left = count;
    assign ad_o       = st_q.addr;
    assign ad_oe      = st_q.ad_oe;
    assign cbe_o      = st_q.cbe;
    assign cbe_oe     = st_q.cbe_oe;
    assign frame_n    = st_q.frame_n;
    assign frame_oe   = st_q.frame_oe;
    assign irdy_n     = st_q.irdy_n;
    assign irdy_oe    = st_q.irdy_oe;
endmodule

// File: rtl/pci_rd_master_chk.sv
module pci_rd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        loc_ready,
    input logic        rd_xfer,
    input logic [3:0]  status,
    input logic [1:0]  term_code,
    input logic        gnt_n,
    input logic        bus_frame_n,
    input logic        bus_irdy_n,
    input logic        trdy_n,
    input logic        devsel_n,
    input logic        ad_oe,
    input logic [3:0]  cbe_o,
    input logic        cbe_oe,
    input logic        frame_n,
    input logic        frame_oe,
    input logic        irdy_n,
    input logic        irdy_oe
);
    AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_oe) |-> (ad_oe && !frame_n && cbe_oe && cbe_o == 4'b0110 && status == 4'd2)) // R2
        else $error("address phase contents wrong");

    AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_oe) |-> ($past(!gnt_n) && $past(bus_frame_n, 2) && $past(bus_irdy_n, 2))) // R3
        else $error("address phase started without grant on idle bus");

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_oe && ad_oe) |=> !ad_oe) // R4
        else $error("AD not released after address phase");

    AST_IRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_oe && !irdy_n && trdy_n) |=> (irdy_oe && !irdy_n)) // R5
        else $error("IRDY# withdrawn before completion");

    AST_XFER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_xfer |-> $past(irdy_oe && !irdy_n && !trdy_n && !devsel_n && loc_ready)) // R7
        else $error("transfer strobe without completion and ready");

    AST_FRAME_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_oe && frame_n) |-> (irdy_oe && !irdy_n)) // R8
        else $error("FRAME# high without IRDY# low");

    AST_TERM_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'd3) |-> (!frame_oe && !ad_oe && !cbe_oe && irdy_oe && irdy_n && term_code == 2'd1)) // R9
        else $error("termination cycle outputs wrong");

    AST_TERM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'd3) |=> (status == 4'd0 && !irdy_oe)) // R1
        else $error("termination did not return to idle");
endmodule

bind pci_rd_master pci_rd_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_ready   (loc_ready),
    .rd_xfer     (rd_xfer),
    .status      (status),
    .term_code   (term_code),
    .gnt_n       (gnt_n),
    .bus_frame_n (bus_frame_n),
    .bus_irdy_n  (bus_irdy_n),
    .trdy_n      (trdy_n),
    .devsel_n    (devsel_n),
    .ad_oe       (ad_oe),
    .cbe_o       (cbe_o),
    .cbe_oe      (cbe_oe),
    .frame_n     (frame_n),
    .frame_oe    (frame_oe),
    .irdy_n      (irdy_n),
    .irdy_oe     (irdy_oe)
);

// File: tb/pci_rd_master_bench.sv
`timescale 1ns/100ps
module pci_rd_master_bench;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             loc_req = 1'b0;
    logic [31:0]      loc_addr = '0;
    logic [LEN_W-1:0] loc_len = '0;
    logic [3:0]       loc_be = '0;
    logic             loc_ready = 1'b0;
    logic [31:0]      rd_data;
    logic             rd_xfer;
    logic [LEN_W-1:0] burst_left;
    logic [3:0]       status;
    logic [1:0]       term_code;
    logic             req_n;
    logic             gnt_n = 1'b0;
    logic             bus_frame_n = 1'b1;
    logic             bus_irdy_n = 1'b1;
    logic             trdy_n = 1'b1;
    logic             devsel_n = 1'b1;
    logic [31:0]      ad_i = '0;
    logic [31:0]      ad_o;
    logic             ad_oe;
    logic [3:0]       cbe_o;
    logic             cbe_oe;
    logic             frame_n;
    logic             frame_oe;
    logic             irdy_n;
    logic             irdy_oe;

    int total = 0;
    int bad   = 0;
    int run_id = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pci_rd_master #(.LEN_W(LEN_W)) u_pci_rd_master (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s run=%0d actual=0x%0h expected=0x%0h", req, run_id, act, exp);
        end
    endtask

    // data phases after FRAME# has been seen asserted at this negedge
    task automatic run_data(input int nw, input logic [31:0] addr, input logic [3:0] be,
                            input logic [7:0] rpat, input logic [7:0] tpat, input logic [31:0] base);
        int  done = 0;
        bit  prev_ready, prev_complete = 1'b0, pending = 1'b0, hold = 1'b0, dropped = 1'b0;
        logic [31:0] last_word = '0;
        bit  ended = 1'b0;
        chk(!frame_n,               "R2 frame low", frame_n, 0);
        chk(ad_oe && ad_o == addr,  "R2 address", ad_o, addr);
        chk(cbe_oe && cbe_o == 4'b0110, "R2 command", cbe_o, 4'b0110);
        chk(status == 4'd2,         "R1 transaction status", status, 2);
        chk(burst_left == LEN_W'(nw), "R2 count load", burst_left, nw);
        chk(req_n == 1'b0,          "R10 req at frame", req_n, 0);
        loc_req   = 1'b0;
        loc_ready = rpat[0];
        prev_ready = rpat[0];
        trdy_n = 1'b1; devsel_n = 1'b1;
        for (int cyc = 1; cyc < 80 && !ended; cyc++) begin
            bit irdy_obs, exp_irdy, trdy_now, comp;
            @(negedge clk);
            if (cyc == 1) begin
                chk(!ad_oe, "R4 turnaround", ad_oe, 0);
                chk(req_n == 1'b1, "R10 req released", req_n, 1);
            end
            chk(rd_xfer == (prev_complete && prev_ready), "R7 strobe", rd_xfer, prev_complete && prev_ready);
            if (prev_complete) begin
                chk(rd_data == last_word, "R6 read word", rd_data, last_word);
                chk(burst_left == LEN_W'(nw - done), "R6 count", burst_left, nw - done);
            end
            if (prev_complete && done == nw) begin
                chk(status == 4'd3 && term_code == 2'd1, "R9 termination code", {status, term_code}, {4'd3, 2'd1});
                chk(!frame_oe && !ad_oe && !cbe_oe, "R9 release", {frame_oe, ad_oe, cbe_oe}, 0);
                chk(irdy_oe && irdy_n, "R9 irdy high", {irdy_oe, irdy_n}, 3);
                loc_ready = 1'b0; trdy_n = 1'b1; devsel_n = 1'b1;
                @(negedge clk);
                chk(!irdy_oe && status == 4'd0 && term_code == 2'd0, "R1 back to idle", {irdy_oe, status, term_code}, 0);
                ended = 1'b1;
            end else begin
                irdy_obs = irdy_oe && !irdy_n;
                exp_irdy = pending ? 1'b1 : prev_ready;
                chk(irdy_obs == exp_irdy, "R5 irdy", irdy_obs, exp_irdy);
                chk(cbe_oe && cbe_o == be, "R4 byte enables", cbe_o, be);
                chk(frame_oe && (frame_n == (dropped || (irdy_obs && done == nw - 1))), "R8 frame",
                    frame_n, dropped || (irdy_obs && done == nw - 1));
                chk(status == 4'd2, "R1 status during data", status, 2);
                trdy_now = tpat[cyc % 8] || hold;
                trdy_n   = !trdy_now;
                devsel_n = 1'b0;
                ad_i     = base + 32'(done);
                loc_ready = rpat[cyc % 8];
                comp = irdy_obs && trdy_now;
                if (comp) begin
                    last_word = base + 32'(done);
                    done++;
                end
                hold = trdy_now && !comp;
                pending = irdy_obs && !comp;
                dropped = dropped || frame_n;
                prev_complete = comp;
                prev_ready = loc_ready;
            end
        end
        if (!ended) chk(1'b0, "R6 burst did not finish", done, nw);
    endtask

    task automatic do_burst(input int len, input logic [7:0] rpat, input logic [7:0] tpat);
        int nw = (len == 0) ? 1 : len;
        logic [31:0] addr = 32'h1000_0000 + 32'(run_id * 64);
        logic [3:0]  be   = 4'(run_id);
        bit seen = 1'b0;
        @(negedge clk);
        loc_addr = addr; loc_len = LEN_W'(len); loc_be = be; loc_req = 1'b1;
        for (int w = 0; w < 6 && !seen; w++) begin
            @(negedge clk);
            if (w == 0) chk(status == 4'd1 && req_n == 1'b0, "R1 loading", {status, req_n}, {4'd1, 1'b0});
            if (frame_oe) seen = 1'b1;
        end
        if (!seen) chk(1'b0, "R3 no address phase", frame_oe, 1);
        else run_data(nw, addr, be, rpat, tpat, 32'hA500_0000 + 32'(run_id * 16));
        run_id++;
    endtask

    initial begin
        logic [7:0] rpats [4] = '{8'hFF, 8'hB6, 8'h5A, 8'h31};
        logic [7:0] tpats [4] = '{8'hFF, 8'h92, 8'h6C, 8'h11};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 4'd0 && term_code == 2'd0, "R1 reset status", status, 0);
        chk(req_n && !frame_oe && !ad_oe && !irdy_oe && !cbe_oe && !rd_xfer, "R10 reset outputs",
            {req_n, frame_oe, ad_oe, irdy_oe, cbe_oe, rd_xfer}, 6'b100000);

        // R3: busy bus and missing grant hold the address phase back
        gnt_n = 1'b1; bus_frame_n = 1'b0;
        loc_addr = 32'h0BAD_F00D; loc_len = LEN_W'(2); loc_be = 4'h3; loc_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(status == 4'd1 && !frame_oe && !req_n, "R3 waits for grant", {status, frame_oe}, {4'd1, 1'b0});
        gnt_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!frame_oe, "R3 waits for idle bus", frame_oe, 0);
        bus_frame_n = 1'b1;
        @(negedge clk);
        chk(!frame_oe, "R3 one cycle idle sample", frame_oe, 0);
        @(negedge clk);
        chk(frame_oe, "R3 starts after idle", frame_oe, 1);
        if (frame_oe) run_data(2, 32'h0BAD_F00D, 4'h3, 8'hFF, 8'hFF, 32'hA500_0000);
        run_id++;

        for (int len = 0; len <= 4; len++)
            for (int ri = 0; ri < 4; ri++)
                for (int ti = 0; ti < 4; ti++)
                    do_burst(len, rpats[ri], tpats[ti]);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule